// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store holding a parameterized number of words, each a parameterized number of bits wide. Nothing is ever written to an address. A write carries only data, and the store puts it into the lowest-numbered empty word. Each word carries a valid bit, and empty words take no part in any search.

A lookup presents a search argument and a care mask. Every stored word is compared with the argument at once. Only bit positions whose mask bit is 1 take part in the comparison. The result is a registered per-word hit vector together with an any-hit flag. A read request returns the contents of the lowest-numbered word that hit. An invalidate request frees every word flagged in the hit vector. The block is meant to serve as a tag or lookup store inside a larger datapath, where software-free hardware needs associative search with wildcard fields.

Top module: `masked_cam`

## Requirements
- R1: After reset, every word is empty and `hit_vec`, `hit_any`, `full_err` and `rd_found` are 0. `rd_word` is also 0.
- R2: When `wr_en` is high and at least one word is empty, `wr_word` is stored in the empty word with the lowest index, and that word becomes valid on the same clock edge. Word i corresponds to bit i of `hit_vec`.
- R3: When `wr_en` is high and every word is valid, the write is dropped and stored contents are unchanged. `full_err` is 1 for exactly the one cycle after that edge.
- R4: A search (`srch_en` high at an edge) loads `hit_vec` on that edge. Bit i is 1 when word i is valid and, for every position j with `care[j]`=1, bit j of word i equals `arg[j]`; otherwise bit i is 0. `hit_vec` then holds until the next search or invalidate.
- R5: With `care` all zeros, every valid word hits. With `care` all ones, only words exactly equal to `arg` hit.
- R6: `hit_any` is 1 exactly when `hit_vec` has at least one bit set, and it updates on the same edge as `hit_vec`.
- R7: On an edge with `rd_en` high, `rd_found` is loaded with 1 and `rd_word` with the contents of the lowest-index word whose `hit_vec` bit is set. If `hit_vec` is all zeros, `rd_found` is loaded with 0 and `rd_word` with 0. Both outputs hold when `rd_en` is low.
- R8: On an edge with `inval_en` high, every word flagged in `hit_vec` becomes empty and `hit_vec` and `hit_any` are cleared. A search on the same edge is ignored.
- R9: A search on the same edge as a write compares against the contents as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store `wr_word` into a free word |
| wr_word | input | WIDTH | Data to store |
| srch_en | input | 1 | Run a masked search |
| arg | input | WIDTH | Search argument |
| care | input | WIDTH | Per-bit compare enable (1 = compare) |
| rd_en | input | 1 | Fetch lowest-index hit word |
| inval_en | input | 1 | Free all words flagged in `hit_vec` |
| hit_vec | output | WORDS | Registered per-word match result |
| hit_any | output | 1 | At least one bit of `hit_vec` set |
| full_err | output | 1 | One-cycle flag: a write found no free word |
| rd_word | output | WIDTH | Data returned by a read |
| rd_found | output | 1 | The last read found a hit |

## Verification
The bench uses a 4-word, 4-bit configuration. It fills the words with data that includes a duplicate, then sweeps every argument against every mask. The all-zero and all-ones masks separate "ignore everything" from exact matching. The partial masks show that the comparison is truly per-bit and not per-field, and the duplicate words show that multi-hit vectors and the lowest-index read choice are correct. A read follows each search and is checked against the bench's own model of the stored words.

The bench then overfills the store, invalidates a hit set, and checks that the refill lands in the freed lowest slot. It also checks the two same-edge orderings: search together with write, and search together with invalidate.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned MAX_WORDS = 64;

  // Position of the lowest set bit, or -1 when the vector is zero.
  function automatic int first_one(input logic [MAX_WORDS-1:0] v);
    int pos;
    pos = -1;
    for (int i = MAX_WORDS - 1; i >= 0; i--) begin
      if (v[i]) pos = i;
    end
    return pos;
  endfunction

  // Masked equality: positions with care=0 never cause a mismatch.
  function automatic logic masked_match(input logic [MAX_WORDS-1:0] stored,
                                        input logic [MAX_WORDS-1:0] probe,
                                        input logic [MAX_WORDS-1:0] mask);
    return ((stored ^ probe) & mask) == '0;
  endfunction
endpackage

// File: rtl/cam_row.sv
module cam_row #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] wdata,
  input  logic             kill,
  input  logic [WIDTH-1:0] arg,
  input  logic [WIDTH-1:0] care,
  output logic [WIDTH-1:0] word,
  output logic             live,
  output logic             hit
);
  import cam_pkg::*;

  logic [MAX_WORDS-1:0] word_x, arg_x, care_x;

  always_comb begin
    word_x = '0;
    arg_x  = '0;
    care_x = '0;
    word_x[WIDTH-1:0] = word;
    arg_x[WIDTH-1:0]  = arg;
    care_x[WIDTH-1:0] = care;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      live <= 1'b0;
    end else if (load) begin
      word <= wdata;
      live <= 1'b1;
    end else if (kill) begin
      live <= 1'b0;
    end
  end

  assign hit = live && masked_match(word_x, arg_x, care_x);

  // R2/R8: a row is never loaded and freed on the same edge
  p_no_load_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && kill));
endmodule

// File: rtl/cam_pick.sv
module cam_pick #(
  parameter int unsigned N    = 8,
  parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  output logic            found,
  output logic [IDXW-1:0] idx
);
  import cam_pkg::*;

  logic [MAX_WORDS-1:0] padded;
  int pos;

  always_comb begin
    padded = '0;
    padded[N-1:0] = req;
    pos   = first_one(padded);
    found = (pos >= 0);
    idx   = found ? IDXW'(pos) : '0;
  end
endmodule

// File: rtl/masked_cam.sv
module masked_cam #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             srch_en,
  input  logic [WIDTH-1:0] arg,
  input  logic [WIDTH-1:0] care,
  input  logic             rd_en,
  input  logic             inval_en,
  output logic [WORDS-1:0] hit_vec,
  output logic             hit_any,
  output logic             full_err,
  output logic [WIDTH-1:0] rd_word,
  output logic             rd_found
);
  localparam int unsigned IDXW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [WIDTH-1:0] word_arr [WORDS];
  logic [WORDS-1:0] valid_vec;
  logic [WORDS-1:0] row_hit;
  logic [WORDS-1:0] row_load;
  logic [WORDS-1:0] row_kill;

  logic            free_found;
  logic [IDXW-1:0] free_idx;
  logic            sel_found;
  logic [IDXW-1:0] sel_idx;

  // named internal events
  logic write_accept;
  logic write_reject;
  logic search_take;

  assign write_accept = wr_en && free_found;
  assign write_reject = wr_en && !free_found;
  assign search_take  = srch_en && !inval_en;

  cam_pick #(.N(WORDS), .IDXW(IDXW)) u_free (
    .req(~valid_vec), .found(free_found), .idx(free_idx)
  );

  cam_pick #(.N(WORDS), .IDXW(IDXW)) u_sel (
    .req(hit_vec), .found(sel_found), .idx(sel_idx)
  );

  for (genvar i = 0; i < WORDS; i++) begin : g_row
    assign row_load[i] = write_accept && (free_idx == IDXW'(i));
    assign row_kill[i] = inval_en && hit_vec[i];
    cam_row #(.WIDTH(WIDTH)) u_row (
      .clk(clk), .rst_n(rst_n),
      .load(row_load[i]), .wdata(wr_word), .kill(row_kill[i]),
      .arg(arg), .care(care),
      .word(word_arr[i]), .live(valid_vec[i]), .hit(row_hit[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_vec  <= '0;
      hit_any  <= 1'b0;
      full_err <= 1'b0;
      rd_word  <= '0;
      rd_found <= 1'b0;
    end else begin
      full_err <= write_reject;
      if (inval_en) begin
        hit_vec <= '0;
        hit_any <= 1'b0;
      end else if (search_take) begin
        hit_vec <= row_hit;
        hit_any <= |row_hit;
      end
      if (rd_en) begin
        rd_found <= sel_found;
        rd_word  <= sel_found ? word_arr[sel_idx] : '0;
      end
    end
  end

  // R8: flagged words are always valid ones
  p_hits_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~valid_vec) == '0);

  // R3: the full flag follows only a write into a full store
  p_full_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_err |-> ($past(wr_en) && $past(&valid_vec)));

  // R2: an accepted write adds exactly one valid word
  p_write_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(&valid_vec) && !inval_en) |=>
      ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

  // R6: any-hit agrees with the vector
  p_any_agrees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any == (|hit_vec));

  // R7: read status reflects the vector at the request edge
  p_read_found_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_found == $past(|hit_vec)));
endmodule

// File: tb/masked_cam_test.sv
`timescale 1ns/1ps
module masked_cam_test;
  localparam int NW = 4;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, srch_en = 1'b0, rd_en = 1'b0, inval_en = 1'b0;
  logic [NB-1:0] wr_word = '0, arg = '0, care = '0;
  logic [NW-1:0] hit_vec;
  logic          hit_any, full_err, rd_found;
  logic [NB-1:0] rd_word;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  logic [NB-1:0] m_mem [NW];
  bit            m_vld [NW];
  logic [NW-1:0] m_hits;

  always #2.5 clk = ~clk;

  masked_cam #(.WORDS(NW), .WIDTH(NB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .srch_en(srch_en), .arg(arg), .care(care), .rd_en(rd_en),
    .inval_en(inval_en), .hit_vec(hit_vec), .hit_any(hit_any),
    .full_err(full_err), .rd_word(rd_word), .rd_found(rd_found)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected hit vector, bit-serial comparison
  function automatic logic [NW-1:0] model_search(input logic [NB-1:0] a, input logic [NB-1:0] k);
    logic [NW-1:0] r;
    for (int w = 0; w < NW; w++) begin
      bit ok;
      ok = m_vld[w];
      for (int b = 0; b < NB; b++)
        if (k[b] && (m_mem[w][b] != a[b])) ok = 0;
      r[w] = ok;
    end
    return r;
  endfunction

  function automatic int model_free();
    for (int w = 0; w < NW; w++) if (!m_vld[w]) return w;
    return -1;
  endfunction

  task automatic do_write(input logic [NB-1:0] d, input string req);
    int slot;
    slot = model_free();
    @(negedge clk); wr_en = 1'b1; wr_word = d;
    @(negedge clk); wr_en = 1'b0;
    if (slot >= 0) begin m_mem[slot] = d; m_vld[slot] = 1; end
    check(req, full_err, (slot < 0));
  endtask

  task automatic do_search(input logic [NB-1:0] a, input logic [NB-1:0] k, input string req);
    @(negedge clk); srch_en = 1'b1; arg = a; care = k;
    @(negedge clk); srch_en = 1'b0;
    m_hits = model_search(a, k);
    check(req, hit_vec, m_hits);
    check("R6", hit_any, |m_hits);
  endtask

  task automatic do_read(input string req);
    logic [NB-1:0] e;
    bit f;
    e = '0; f = 0;
    for (int w = NW - 1; w >= 0; w--) if (m_hits[w]) begin e = m_mem[w]; f = 1; end
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(req, rd_found, f);
    check(req, rd_word, e);
  endtask

  task automatic do_inval();
    @(negedge clk); inval_en = 1'b1;
    @(negedge clk); inval_en = 1'b0;
    for (int w = 0; w < NW; w++) if (m_hits[w]) m_vld[w] = 0;
    m_hits = '0;
    check("R8", hit_vec, 0);
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin m_mem[w] = '0; m_vld[w] = 0; end
    m_hits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", {hit_vec, hit_any, full_err, rd_found}, 0);
    check("R1", rd_word, 0);
    do_search(4'h0, 4'h0, "R1");   // all empty: wildcard still finds nothing

    // R2: fill in lowest-free order, with a duplicate
    do_write(4'h3, "R2");
    do_search(4'h3, 4'hF, "R2");
    do_write(4'hA, "R2");
    do_write(4'h3, "R2");
    do_write(4'h5, "R2");
    do_search(4'h0, 4'h0, "R2");
    // R3: write to full store rejected, contents unchanged
    do_write(4'hF, "R3");
    @(negedge clk);
    check("R3", full_err, 0);
    do_search(4'hF, 4'hF, "R3");

    // R4/R5/R7: sweep every argument against every mask
    for (int k = 0; k < 16; k++) begin
      for (int a = 0; a < 16; a++) begin
        do_search(NB'(a), NB'(k), (k == 0 || k == 15) ? "R5" : "R4");
        do_read("R7");
      end
    end

    // R4: result holds without a new search
    do_search(4'h3, 4'hF, "R4");
    repeat (3) @(negedge clk);
    check("R4", hit_vec, 4'b0101);

    // R8: invalidate words 0 and 2, refill lands in slot 0
    do_inval();
    do_search(4'h0, 4'h0, "R8");
    do_write(4'h9, "R8");
    do_search(4'h9, 4'hF, "R8");
    check("R8", hit_vec, 4'b0001);

    // R8: invalidate beats a same-edge search
    do_search(4'hA, 4'hF, "R8");
    @(negedge clk); inval_en = 1'b1; srch_en = 1'b1; arg = 4'h0; care = 4'h0;
    @(negedge clk); inval_en = 1'b0; srch_en = 1'b0;
    m_vld[1] = 0; m_hits = '0;
    check("R8", {hit_vec, hit_any}, 0);
    do_read("R7");

    // R9: search and write on the same edge; slot 1 is lowest free
    @(negedge clk); srch_en = 1'b1; arg = 4'hC; care = 4'hF; wr_en = 1'b1; wr_word = 4'hC;
    @(negedge clk); srch_en = 1'b0; wr_en = 1'b0;
    check("R9", hit_vec, 0);
    m_mem[1] = 4'hC; m_vld[1] = 1;
    do_search(4'hC, 4'hF, "R9");
    check("R9", hit_vec, 4'b0010);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule